// File: doc/BRIEF.md
# Load Address and Extension Unit

This block sits in the address and writeback stage of a 64-bit load pipeline. From a decoded primary opcode, a base register value and a signed 16-bit displacement it forms the effective address and the read size that go to memory. From the 64-bit word that memory returns it picks the addressed lane and widens it to the destination register width, zero-filled or sign-filled as the opcode demands.

One opcode is an add-high arithmetic form. It never touches memory. It writes back the base plus the displacement moved up by 16 bits. Another opcode is an unaligned-quadword load whose address is forced down to an 8-byte boundary. Any other opcode is flagged as illegal and produces no writeback and no read.

The datapath from the inputs is combinational, and all results are captured in one output register stage. The results of an operation presented with `in_valid` high therefore appear, together with `out_valid`, one clock later.

Top module: `load_agu_ext`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wb_en`, `mem_rd` and `illegal` are all 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and all other outputs of that operation appear in that same cycle, including for back-to-back operations.
- R3: The 16-bit displacement is treated as a two's-complement value widened to 64 bits before any add or shift, so 0xFFFF adds -1 and 0x8000 adds -32768.
- R4: Opcode 0x09 gives `wb_data` = base + (widened displacement << 16), with `wb_en`=1 and `mem_rd`=0.
- R5: Opcode 0x0b gives `ea` = (base + displacement) with bits [2:0] cleared, `rd_size`=3, `mem_rd`=1, and `wb_data` equal to the full 64-bit read data.
- R6: Opcode 0x0a gives `ea` = base + displacement and `rd_size`=0. `wb_data` is byte lane `ea[2:0]` of the read data (lane 0 = bits [7:0]), with upper bits zero.
- R7: Opcode 0x0c gives `ea` = base + displacement and `rd_size`=1. `wb_data` is 16-bit lane `ea[2:1]` of the read data (lane 0 = bits [15:0]), with upper bits zero.
- R8: Opcode 0x2a gives `ea` = base + displacement and `rd_size`=2. `wb_data` is 32-bit lane `ea[2]` (lane 0 = bits [31:0]), with its bit 31 copied into bits [63:32].
- R9: Opcode 0x2b gives `ea` = base + displacement, `rd_size`=3, and `wb_data` equal to the full read data.
- R10: Any opcode other than 0x09, 0x0a, 0x0b, 0x0c, 0x2a or 0x2b gives `illegal`=1, `wb_en`=0 and `mem_rd`=0.
- R11: In the cycle after a cycle with `in_valid` low, `out_valid`, `wb_en`, `mem_rd` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 6 | Decoded primary opcode |
| base | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| rdata | input | 64 | Read data returned from memory for this operation |
| out_valid | output | 1 | Registered results are valid |
| ea | output | 64 | Effective address |
| rd_size | output | 2 | Read size: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| mem_rd | output | 1 | The operation reads memory |
| wb_en | output | 1 | The destination register is written |
| wb_data | output | 64 | Value for the destination register |
| illegal | output | 1 | The opcode is not supported |

## Verification
The hardest cases to reach are the ones where the displacement carries into the low address bits that pick the lane. A negative displacement can move a byte load onto lane 7. An odd address on a 16-bit load must still use lane `ea[2:1]`. An unaligned quadword load must clear bits that the add just produced. The stimulus therefore picks base and displacement pairs so that the sum, not the base, lands on each of these offsets. It uses read data whose lanes all have their top bit set, so that any wrong zero-fill or sign-fill shows in `wb_data`.

// File: rtl/lax_pkg.sv
package lax_pkg;

   localparam logic [5:0] OPC_ADDHI = 6'h09;
   localparam logic [5:0] OPC_LDB   = 6'h0a;
   localparam logic [5:0] OPC_LDQU  = 6'h0b;
   localparam logic [5:0] OPC_LDW   = 6'h0c;
   localparam logic [5:0] OPC_LDL   = 6'h2a;
   localparam logic [5:0] OPC_LDQ   = 6'h2b;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_QUAD = 2'd3
   } lax_size_e;

   typedef struct packed {
      logic      legal;
      logic      addhi;
      logic      mem;
      logic      align;
      logic      sext;
      lax_size_e size;
   } lax_ctl_t;

endpackage

// File: rtl/lax_decode.sv
module lax_decode
   import lax_pkg::*;
(
   input  logic [5:0] opcode,
   output lax_ctl_t   ctl
);

   always_comb begin
      ctl = '{legal: 1'b0, addhi: 1'b0, mem: 1'b0, align: 1'b0,
              sext: 1'b0, size: SZ_BYTE};
      unique case (opcode)
         OPC_ADDHI: begin
            ctl.legal = 1'b1;
            ctl.addhi = 1'b1;
         end
         OPC_LDB: begin
            ctl.legal = 1'b1;
            ctl.mem   = 1'b1;
            ctl.size  = SZ_BYTE;
         end
         OPC_LDW: begin
            ctl.legal = 1'b1;
            ctl.mem   = 1'b1;
            ctl.size  = SZ_WORD;
         end
         OPC_LDL: begin
            ctl.legal = 1'b1;
            ctl.mem   = 1'b1;
            ctl.sext  = 1'b1;
            ctl.size  = SZ_LONG;
         end
         OPC_LDQ: begin
            ctl.legal = 1'b1;
            ctl.mem   = 1'b1;
            ctl.size  = SZ_QUAD;
         end
         OPC_LDQU: begin
            ctl.legal = 1'b1;
            ctl.mem   = 1'b1;
            ctl.align = 1'b1;
            ctl.size  = SZ_QUAD;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lax_addr.sv
module lax_addr #(
   parameter int XLEN     = 64,
   parameter int DISP_W   = 16,
   parameter int HI_SHIFT = 16
) (
   input  logic [XLEN-1:0]   base,
   input  logic [DISP_W-1:0] disp,
   input  logic              align,
   output logic [XLEN-1:0]   ea,
   output logic [XLEN-1:0]   hi_sum
);

   localparam int BYTES  = XLEN / 8;
   localparam int ALIGNB = $clog2(BYTES);

   logic [XLEN-1:0] disp_x;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] align_mask;

   assign disp_x = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
   assign sum    = base + disp_x;
   assign hi_sum = base + (disp_x << HI_SHIFT);

   genvar b;
   generate
      for (b = 0; b < XLEN; b++) begin : g_mask
         if (b < ALIGNB) begin : g_low
            assign align_mask[b] = ~align;
         end else begin : g_high
            assign align_mask[b] = 1'b1;
         end
      end
   endgenerate

   assign ea = sum & align_mask;

endmodule

// File: rtl/lax_extract.sv
module lax_extract
   import lax_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]            rdata,
   input  logic [$clog2(XLEN/8)-1:0] off,
   input  lax_size_e                 size,
   input  logic                      sext,
   output logic [XLEN-1:0]           value
);

   localparam int OFF_W = $clog2(XLEN/8);
   localparam int NB    = XLEN / 8;
   localparam int NW    = XLEN / 16;
   localparam int NL    = XLEN / 32;

   logic [7:0]  byte_lane [NB];
   logic [15:0] word_lane [NW];
   logic [31:0] long_lane [NL];

   genvar i;
   generate
      for (i = 0; i < NB; i++) begin : g_b
         assign byte_lane[i] = rdata[8*i +: 8];
      end
      for (i = 0; i < NW; i++) begin : g_w
         assign word_lane[i] = rdata[16*i +: 16];
      end
      for (i = 0; i < NL; i++) begin : g_l
         assign long_lane[i] = rdata[32*i +: 32];
      end
   endgenerate

   logic [7:0]  sel_b;
   logic [15:0] sel_w;
   logic [31:0] sel_l;

   assign sel_b = byte_lane[off];
   assign sel_w = word_lane[off[OFF_W-1:1]];
   assign sel_l = long_lane[off[OFF_W-1:2]];

   always_comb begin
      unique case (size)
         SZ_BYTE: value = {{(XLEN-8){sext & sel_b[7]}}, sel_b};
         SZ_WORD: value = {{(XLEN-16){sext & sel_w[15]}}, sel_w};
         SZ_LONG: value = {{(XLEN-32){sext & sel_l[31]}}, sel_l};
         default: value = rdata;
      endcase
   end

endmodule

// File: rtl/load_agu_ext.sv
module load_agu_ext
   import lax_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int DISP_W   = 16,
   parameter int HI_SHIFT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [5:0]        opcode,
   input  logic [XLEN-1:0]   base,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   rdata,
   output logic              out_valid,
   output logic [XLEN-1:0]   ea,
   output logic [1:0]        rd_size,
   output logic              mem_rd,
   output logic              wb_en,
   output logic [XLEN-1:0]   wb_data,
   output logic              illegal
);

   localparam int OFF_W = $clog2(XLEN/8);

   initial begin
      if (XLEN < 64 || (XLEN & (XLEN-1)) != 0)
         $error("load_agu_ext: XLEN must be a power of two of at least 64");
      if (DISP_W < 2 || DISP_W > XLEN)
         $error("load_agu_ext: DISP_W out of range");
      if (HI_SHIFT < 0 || HI_SHIFT >= XLEN)
         $error("load_agu_ext: HI_SHIFT out of range");
   end

   lax_ctl_t        ctl;
   logic [XLEN-1:0] ea_c;
   logic [XLEN-1:0] hi_c;
   logic [XLEN-1:0] ext_c;
   logic [XLEN-1:0] wb_c;

   lax_decode u_dec (
      .opcode (opcode),
      .ctl    (ctl)
   );

   lax_addr #(
      .XLEN     (XLEN),
      .DISP_W   (DISP_W),
      .HI_SHIFT (HI_SHIFT)
   ) u_addr (
      .base   (base),
      .disp   (disp),
      .align  (ctl.align),
      .ea     (ea_c),
      .hi_sum (hi_c)
   );

   lax_extract #(
      .XLEN (XLEN)
   ) u_ext (
      .rdata (rdata),
      .off   (ea_c[OFF_W-1:0]),
      .size  (ctl.size),
      .sext  (ctl.sext),
      .value (ext_c)
   );

   always_comb begin
      if (!ctl.legal)     wb_c = '0;
      else if (ctl.addhi) wb_c = hi_c;
      else                wb_c = ext_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         mem_rd    <= 1'b0;
         wb_en     <= 1'b0;
         illegal   <= 1'b0;
         ea        <= '0;
         rd_size   <= 2'd0;
         wb_data   <= '0;
      end else begin
         out_valid <= in_valid;
         mem_rd    <= in_valid & ctl.mem;
         wb_en     <= in_valid & ctl.legal;
         illegal   <= in_valid & ~ctl.legal;
         if (in_valid) begin
            ea      <= ea_c;
            rd_size <= ctl.size;
            wb_data <= wb_c;
         end
      end
   end

endmodule

// File: rtl/load_agu_ext_chk.sv
module load_agu_ext_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [5:0]      opcode,
   input logic            out_valid,
   input logic [XLEN-1:0] ea,
   input logic            mem_rd,
   input logic            wb_en,
   input logic [XLEN-1:0] wb_data,
   input logic            illegal
);

   logic known_op;
   assign known_op = (opcode == 6'h09) || (opcode == 6'h0a) || (opcode == 6'h0b) ||
                     (opcode == 6'h0c) || (opcode == 6'h2a) || (opcode == 6'h2b);

   always @(posedge clk) begin
      // R1
      reset_quiet_chk: assert (rst_n || !(out_valid || wb_en || mem_rd || illegal));
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !(out_valid || wb_en || mem_rd || illegal));

   // R4
   addhi_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 6'h09) |=> (wb_en && !mem_rd));

   // R5
   quad_u_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 6'h0b) |=> (ea[2:0] == 3'b000 && mem_rd));

   // R6
   byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 6'h0a) |=> (wb_data[XLEN-1:8] == '0));

   // R7
   word_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 6'h0c) |=> (wb_data[XLEN-1:16] == '0));

   // R8
   long_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 6'h2a) |=>
         (wb_data[XLEN-1:31] == '0 || wb_data[XLEN-1:31] == '1));

   // R10
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !known_op) |=> (illegal && !wb_en && !mem_rd));

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal && (wb_en || mem_rd)));

endmodule

bind load_agu_ext load_agu_ext_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .opcode    (opcode),
   .out_valid (out_valid),
   .ea        (ea),
   .mem_rd    (mem_rd),
   .wb_en     (wb_en),
   .wb_data   (wb_data),
   .illegal   (illegal)
);

// File: tb/load_agu_ext_bench.sv
module load_agu_ext_bench;

   typedef struct {
      bit          v;
      bit          wb;
      bit          mr;
      bit          il;
      logic [1:0]  sz;
      logic [63:0] ea;
      logic [63:0] wd;
      bit          chk_ea;
      bit          chk_wd;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  opcode = '0;
   logic [63:0] base = '0;
   logic [15:0] disp = '0;
   logic [63:0] rdata = '0;
   logic        out_valid;
   logic [63:0] ea;
   logic [1:0]  rd_size;
   logic        mem_rd;
   logic        wb_en;
   logic [63:0] wb_data;
   logic        illegal;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #4 clk = ~clk;

   load_agu_ext u_load_agu_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .opcode    (opcode),
      .base      (base),
      .disp      (disp),
      .rdata     (rdata),
      .out_valid (out_valid),
      .ea        (ea),
      .rd_size   (rd_size),
      .mem_rd    (mem_rd),
      .wb_en     (wb_en),
      .wb_data   (wb_data),
      .illegal   (illegal)
   );

   function automatic exp_t model(input logic [5:0] op, input logic [63:0] b,
                                  input logic [15:0] d, input logic [63:0] rd,
                                  input string tag);
      exp_t        e;
      logic [63:0] dx;
      logic [63:0] a;
      dx = {{48{d[15]}}, d};
      a  = b + dx;
      e.v = 1; e.tag = tag; e.chk_ea = 1; e.chk_wd = 1;
      e.wb = 1; e.mr = 1; e.il = 0; e.sz = 2'd0;
      case (op)
         6'h09: begin
            e.mr = 0; e.chk_ea = 0;
            e.wd = b + (dx << 16);
         end
         6'h0a: begin
            e.ea = a; e.sz = 2'd0;
            e.wd = {56'd0, rd[8*a[2:0] +: 8]};
         end
         6'h0c: begin
            e.ea = a; e.sz = 2'd1;
            e.wd = {48'd0, rd[16*a[2:1] +: 16]};
         end
         6'h2a: begin
            e.ea = a; e.sz = 2'd2;
            e.wd = {{32{rd[32*a[2]+31]}}, rd[32*a[2] +: 32]};
         end
         6'h2b: begin
            e.ea = a; e.sz = 2'd3; e.wd = rd;
         end
         6'h0b: begin
            e.ea = {a[63:3], 3'b000}; e.sz = 2'd3; e.wd = rd;
         end
         default: begin
            e.wb = 0; e.mr = 0; e.il = 1; e.chk_ea = 0; e.chk_wd = 0;
         end
      endcase
      return e;
   endfunction

   task automatic drv(input logic [5:0] op, input logic [63:0] b,
                      input logic [15:0] d, input logic [63:0] rd, input string tag);
      @(negedge clk);
      in_valid = 1'b1; opcode = op; base = b; disp = d; rdata = rd;
      q.push_back(model(op, b, d, rd, tag));
   endtask

   task automatic idle(input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b0; opcode = 6'h2b; base = '1; disp = '1; rdata = '1;
      e.v = 0; e.wb = 0; e.mr = 0; e.il = 0; e.sz = 0; e.ea = 0; e.wd = 0;
      e.chk_ea = 0; e.chk_wd = 0; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      bit   bad;
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            bad = (out_valid !== e.v) || (wb_en !== e.wb) || (mem_rd !== e.mr) ||
                  (illegal !== e.il);
            if (e.mr && rd_size !== e.sz) bad = 1;
            if (e.chk_ea && ea !== e.ea) bad = 1;
            if (e.chk_wd && wb_data !== e.wd) bad = 1;
            if (bad) begin
               n_err++;
               $display("FAIL %s: got v=%b wb=%b rd=%b il=%b sz=%0d ea=%h data=%h, expected v=%b wb=%b rd=%b il=%b sz=%0d ea=%h data=%h",
                        e.tag, out_valid, wb_en, mem_rd, illegal, rd_size, ea, wb_data,
                        e.v, e.wb, e.mr, e.il, e.sz, e.ea, e.wd);
            end
         end
      end
   end

   initial begin : watchdog
      #(8 * 20000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   localparam logic [63:0] HI_BYTES = 64'hF7F6_F5F4_F3F2_F1F0;

   initial begin : stim
      repeat (3) @(posedge clk);
      #2;
      n_chk++;
      // R1: reset state
      if (out_valid !== 0 || wb_en !== 0 || mem_rd !== 0 || illegal !== 0) begin
         n_err++;
         $display("FAIL R1: got v=%b wb=%b rd=%b il=%b, expected all 0",
                  out_valid, wb_en, mem_rd, illegal);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle("R11 idle after reset");
      drv(6'h09, 64'h1000, 16'h0002, HI_BYTES, "R4 add-high positive");
      drv(6'h09, 64'h1_0000_0000, 16'h8000, HI_BYTES, "R3 R4 add-high negative");
      drv(6'h0a, 64'h1000, 16'h0005, HI_BYTES, "R6 byte lane 5");
      drv(6'h0a, 64'h100, 16'hFFFF, HI_BYTES, "R3 R6 byte lane 7 via -1");
      drv(6'h0c, 64'h2004, 16'h0002, HI_BYTES, "R7 word lane 3");
      drv(6'h0c, 64'h2000, 16'h0003, HI_BYTES, "R7 word odd address");
      drv(6'h2a, 64'h3000, 16'h0004, HI_BYTES, "R8 long negative upper lane");
      drv(6'h2a, 64'h3008, 16'hFFF8, 64'h1234_5678_7654_3210, "R8 long positive lane 0");
      drv(6'h2b, 64'h4000, 16'h0010, 64'h8000_0000_0000_0001, "R9 quad");
      drv(6'h0b, 64'h1003, 16'h0006, 64'hDEAD_BEEF_0123_4567, "R5 unaligned quad");
      drv(6'h0b, 64'h1000, 16'hFFFF, HI_BYTES, "R3 R5 unaligned quad borrow");
      drv(6'h00, 64'h5000, 16'h0000, HI_BYTES, "R10 illegal 0x00");
      idle("R11 idle between ops");
      drv(6'h3f, 64'h5000, 16'h0001, HI_BYTES, "R10 illegal 0x3f");
      drv(6'h0d, 64'h5000, 16'h0001, HI_BYTES, "R10 illegal 0x0d");
      drv(6'h0a, 64'h7000, 16'h0000, HI_BYTES, "R2 back-to-back 1");
      drv(6'h2b, 64'h7008, 16'h0000, HI_BYTES, "R2 back-to-back 2");
      idle("R11 idle final");
      idle("R11 idle final 2");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule